// File: doc/BRIEF.md
# Configuration Page Word Reader

This block fetches single 32-bit words from a small, fixed-size configuration page held in nonvolatile memory. Software loads a byte offset into an offset register and writes the start bit of the command register. The unit then issues one read request on a valid/ready memory port, waits as long as the response needs, and stores the returned word in a data register. A done flag then rises in the status register. The access goes ahead even while the device protection input is asserted.

The offset is always interpreted inside the page. Only the word-index bits are stored, so any bits above the page boundary and the two byte-lane bits are dropped. When a read finishes, the stored word index advances by one on its own and wraps at the end of the page. Software can therefore dump consecutive words by issuing repeated start commands without rewriting the offset.

Software reaches the registers through a register port with a write strobe, a 2-bit select, write data and combinational read data. Select codes: 0 command, 1 offset, 2 data, 3 status.

Top module: `pgrd_top`

## Requirements
- R1: After reset the status register reads 0, the offset register reads 0, the data register reads 0 and `mem_req_valid` is low.
- R2: Writing select 0 with bit 0 set while idle starts a read. From the next cycle `mem_req_valid` is high and `mem_req_idx` equals the stored word index. The status state field (bits [1:0]) reads 1 for the whole read, from launch until the response is taken.
- R3: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and `mem_req_idx` stays unchanged.
- R4: In the cycle after `mem_rsp_valid` is seen for an accepted request, the data register (select 2) holds `mem_rsp_data`, status bit 8 (done) is 1 and the state field returns to 0. Any number of wait cycles may come before the response.
- R5: A start command that is accepted clears the done bit from the next cycle.
- R6: On completion the stored word index increments by one and wraps from 127 to 0. The offset register reads back as the index shifted left by 2.
- R7: A write to the offset register keeps only write-data bits [8:2]. Bits [1:0] and bits [31:9] are discarded, as a read-back shows.
- R8: Exactly one memory request is issued per command. After the request handshake `mem_req_valid` stays low until the next accepted start. A start written while a read is in progress is ignored.
- R9: Asserting `prot_i` does not block or alter a read. Its level is mirrored in status bit 16.
- R10: A write to the offset register while a read is in progress is ignored.
- R11: A `mem_rsp_valid` pulse while idle changes neither the data register nor the done bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prot_i | input | 1 | Device protection flag (does not gate the read) |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 command, 1 offset, 2 data, 3 status |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational on select) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_idx | output | 7 | Word index inside the page |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |

## Verification
The hardest situation to reach from the ports is a command or offset write that lands while a read is still in flight. It has to be tried both while the request waits for `mem_req_ready` and while the response is pending. The bench holds back ready and response for chosen cycle counts so that these writes fall into each phase. It then checks that no second request appears and that the index advances only from its original value. The wrap from index 127 to 0 is reached by loading the top offset directly, which the bench does with an out-of-page value that also exercises the bit trimming.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_AWAIT = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    CSR_CMD  = 2'd0,
    CSR_OFFS = 2'd1,
    CSR_DATA = 2'd2,
    CSR_STAT = 2'd3
  } csr_sel_e;

  localparam int unsigned CMD_GO_BIT    = 0;
  localparam int unsigned STAT_DONE_BIT = 8;
  localparam int unsigned STAT_PROT_BIT = 16;

  localparam logic [1:0] STAT_CODE_IDLE = 2'd0;
  localparam logic [1:0] STAT_CODE_PGRD = 2'd1;

endpackage

// File: rtl/pgrd_rst_sync.sv
module pgrd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pgrd_seq.sv
module pgrd_seq
  import pgrd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  output logic busy,
  output logic req_valid,
  output logic launch,
  output logic finish
);

  seq_state_e state_q, state_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (go)            state_d = SEQ_ISSUE;
      SEQ_ISSUE: if (mem_req_ready) state_d = SEQ_AWAIT;
      SEQ_AWAIT: if (mem_rsp_valid) state_d = SEQ_IDLE;
      default:                      state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign busy      = (state_q != SEQ_IDLE);
  assign req_valid = (state_q == SEQ_ISSUE);
  assign launch    = (state_q == SEQ_IDLE)  && go;
  assign finish    = (state_q == SEQ_AWAIT) && mem_rsp_valid;

endmodule

// File: rtl/pgrd_offset.sv
module pgrd_offset #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned LSB    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              step,
  output logic [IDX_W-1:0]  idx
);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  // only the in-page word index is kept; lanes and upper bits drop out
  always_comb begin
    idx_en = wr_en | step;
    if (wr_en) begin
      idx_d = wr_data[LSB +: IDX_W];
    end else begin
      idx_d = idx_q + {{(IDX_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/pgrd_csr.sv
module pgrd_csr
  import pgrd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned LSB    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              launch,
  input  logic              finish,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [IDX_W-1:0]  idx,
  input  logic              prot,
  output logic [DATA_W-1:0] rdata,
  output logic              go,
  output logic              offs_wr,
  output logic              done
);

  logic [DATA_W-1:0] data_q;
  logic              done_q, done_d, done_en;
  csr_sel_e          sel_e;

  assign sel_e   = csr_sel_e'(sel);
  assign go      = we && (sel_e == CSR_CMD) && wdata[CMD_GO_BIT];
  assign offs_wr = we && (sel_e == CSR_OFFS) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (finish) begin
      data_q <= rsp_data;
    end
  end

  always_comb begin
    done_en = launch | finish;
    done_d  = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (done_en) begin
      done_q <= done_d;
    end
  end

  assign done = done_q;

  always_comb begin
    rdata = '0;
    unique case (sel_e)
      CSR_CMD:  rdata = '0;
      CSR_OFFS: rdata[LSB +: IDX_W] = idx;
      CSR_DATA: rdata = data_q;
      CSR_STAT: begin
        rdata[1:0]           = busy ? STAT_CODE_PGRD : STAT_CODE_IDLE;
        rdata[STAT_DONE_BIT] = done_q;
        rdata[STAT_PROT_BIT] = prot;
      end
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/pgrd_top.sv
module pgrd_top #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PAGE_BYTES = 512
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          prot_i,
  input  logic                                          csr_we,
  input  logic [1:0]                                    csr_sel,
  input  logic [DATA_W-1:0]                             csr_wdata,
  output logic [DATA_W-1:0]                             csr_rdata,
  output logic                                          mem_req_valid,
  input  logic                                          mem_req_ready,
  output logic [$clog2(PAGE_BYTES)-$clog2(DATA_W/8)-1:0] mem_req_idx,
  input  logic                                          mem_rsp_valid,
  input  logic [DATA_W-1:0]                             mem_rsp_data
);

  localparam int unsigned LSB   = $clog2(DATA_W/8);
  localparam int unsigned IDX_W = $clog2(PAGE_BYTES) - LSB;

  logic             rst_sync_n;
  logic             go_w, offs_wr_w, busy_w, launch_w, finish_w, done_w;
  logic [IDX_W-1:0] idx_w;

  pgrd_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  pgrd_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .go           (go_w),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .busy         (busy_w),
    .req_valid    (mem_req_valid),
    .launch       (launch_w),
    .finish       (finish_w)
  );

  pgrd_offset #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LSB(LSB)) u_offs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (offs_wr_w),
    .wr_data(csr_wdata),
    .step   (finish_w),
    .idx    (idx_w)
  );

  pgrd_csr #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LSB(LSB)) u_csr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (csr_we),
    .sel     (csr_sel),
    .wdata   (csr_wdata),
    .busy    (busy_w),
    .launch  (launch_w),
    .finish  (finish_w),
    .rsp_data(mem_rsp_data),
    .idx     (idx_w),
    .prot    (prot_i),
    .rdata   (csr_rdata),
    .go      (go_w),
    .offs_wr (offs_wr_w),
    .done    (done_w)
  );

  assign mem_req_idx = idx_w;

endmodule

// File: rtl/pgrd_chk.sv
module pgrd_chk #(
  parameter int unsigned IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [IDX_W-1:0] mem_req_idx,
  input logic             mem_rsp_valid,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] idx
);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_idx));

  // R8
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R4
  done_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_req_valid && mem_rsp_valid |=> done && !busy);

  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_req_valid && mem_rsp_valid |=> idx == IDX_W'($past(idx) + 1'b1));

  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done);

  // R2
  launch_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req_valid);

endmodule

bind pgrd_top pgrd_chk #(.IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_idx  (mem_req_idx),
  .mem_rsp_valid(mem_rsp_valid),
  .busy         (busy_w),
  .done         (done_w),
  .idx          (idx_w)
);

// File: tb/sim_pgrd_top.sv
module sim_pgrd_top;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        prot_i;
  logic        csr_we;
  logic [1:0]  csr_sel;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [6:0]  mem_req_idx;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int checks = 0;
  int errors = 0;

  pgrd_top u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .prot_i       (prot_i),
    .csr_we       (csr_we),
    .csr_sel      (csr_sel),
    .csr_wdata    (csr_wdata),
    .csr_rdata    (csr_rdata),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_idx  (mem_req_idx),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = s; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0; csr_wdata = '0;
  endtask

  task automatic csr_rd(input logic [1:0] s, output logic [31:0] d);
    csr_sel = s;
    #1;
    d = csr_rdata;
  endtask

  // full read with chosen stall and latency; checks every phase
  task automatic do_read(input int exp_idx, input logic [31:0] word,
                         input int rdy_dly, input int rsp_dly);
    logic [31:0] v;
    csr_wr(2'd0, 32'h1);
    csr_rd(2'd3, v);
    chk("R2 state code in flight", {30'b0, v[1:0]}, 32'd1);
    chk("R5 done cleared on start", {31'b0, v[8]}, 32'd0);
    chk("R2 req valid", {31'b0, mem_req_valid}, 32'd1);
    chk("R2 req idx", {25'b0, mem_req_idx}, exp_idx);
    for (int i = 0; i < rdy_dly; i++) begin
      @(negedge clk);
      chk("R3 valid held", {31'b0, mem_req_valid}, 32'd1);
      chk("R3 idx held", {25'b0, mem_req_idx}, exp_idx);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R8 valid dropped after handshake", {31'b0, mem_req_valid}, 32'd0);
    for (int i = 0; i < rsp_dly; i++) begin
      @(negedge clk);
      csr_rd(2'd3, v);
      chk("R4 no early done", {31'b0, v[8]}, 32'd0);
      chk("R2 state held while waiting", {30'b0, v[1:0]}, 32'd1);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = word;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = 32'hDEAD_0000;
    csr_rd(2'd3, v);
    chk("R4 done set", {31'b0, v[8]}, 32'd1);
    chk("R4 state idle", {30'b0, v[1:0]}, 32'd0);
    csr_rd(2'd2, v);
    chk("R4 data captured", v, word);
    csr_rd(2'd1, v);
    chk("R6 offset advanced", v, ((exp_idx + 1) % 128) << 2);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    csr_rd(2'd3, v); chk("R1 status reset", v, 32'd0);
    csr_rd(2'd1, v); chk("R1 offset reset", v, 32'd0);
    csr_rd(2'd2, v); chk("R1 data reset", v, 32'd0);
    chk("R1 req idle", {31'b0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_basic();
    csr_wr(2'd1, 32'h0000_0010);
    do_read(4, 32'hA5A5_1234, 0, 1);
  endtask

  task automatic t_stall();
    do_read(5, 32'h0BAD_F00D, 3, 5);
  endtask

  task automatic t_dump();
    do_read(6, 32'h1111_0006, 1, 0);
    do_read(7, 32'h1111_0007, 0, 2);
    do_read(8, 32'h1111_0008, 2, 1);
  endtask

  task automatic t_trim();
    logic [31:0] v;
    csr_wr(2'd1, 32'hFFFF_FE0F);
    csr_rd(2'd1, v); chk("R7 offset trimmed", v, 32'h0000_000C);
    csr_wr(2'd1, 32'h0000_0003);
    csr_rd(2'd1, v); chk("R7 lane bits dropped", v, 32'h0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    csr_wr(2'd1, 32'h0000_03FF);
    csr_rd(2'd1, v); chk("R7 top index kept", v, 32'h0000_01FC);
    do_read(127, 32'hCAFE_007F, 0, 0);
    csr_rd(2'd1, v); chk("R6 wrap to zero", v, 32'h0);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    csr_wr(2'd1, 32'h0000_0028);
    csr_wr(2'd0, 32'h1);
    csr_wr(2'd0, 32'h1);
    csr_wr(2'd1, 32'h0000_0100);
    chk("R8 still one request", {31'b0, mem_req_valid}, 32'd1);
    chk("R10 idx unchanged while issuing", {25'b0, mem_req_idx}, 32'd10);
    csr_rd(2'd1, v); chk("R10 offset write ignored", v, 32'h0000_0028);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    csr_wr(2'd0, 32'h1);
    chk("R8 no second request", {31'b0, mem_req_valid}, 32'd0);
    csr_wr(2'd1, 32'h0000_0004);
    csr_rd(2'd3, v); chk("R8 state unchanged", {30'b0, v[1:0]}, 32'd1);
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'h5A5A_000A;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    csr_rd(2'd2, v); chk("R4 data after busy writes", v, 32'h5A5A_000A);
    csr_rd(2'd1, v); chk("R10 index from original", v, 32'h0000_002C);
    @(negedge clk);
    chk("R8 no request after finish", {31'b0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_prot();
    logic [31:0] v;
    prot_i = 1'b1;
    csr_rd(2'd3, v); chk("R9 prot mirrored", {31'b0, v[16]}, 32'd1);
    do_read(11, 32'h7777_000B, 1, 1);
    prot_i = 1'b0;
    csr_rd(2'd3, v); chk("R9 prot low", {31'b0, v[16]}, 32'd0);
  endtask

  task automatic t_stray();
    logic [31:0] v;
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0DD0_0DD0;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    csr_rd(2'd2, v); chk("R11 data kept", v, 32'h7777_000B);
    csr_rd(2'd3, v); chk("R11 done kept", {31'b0, v[8]}, 32'd1);
    csr_rd(2'd1, v); chk("R11 offset kept", v, 32'h0000_0030);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prot_i = 1'b0; csr_we = 1'b0; csr_sel = 2'd0;
    csr_wdata = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_stall();
    t_dump();
    t_trim();
    t_wrap();
    t_busy();
    t_prot();
    t_stray();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule